// File: doc/BRIEF.md
# GPIO Port with Pin Interrupt Capture

A general-purpose I/O port of `N` pins (32 by default) sits behind a small memory-mapped register bus. Software drives output levels and output enables and reads back the synchronised pin levels. Each pin can also raise an interrupt. A pin takes part only when its capture-select bit is set. Two independent bits set its trigger: a mode bit chooses level or edge, and a polarity bit chooses high/rising or low/falling. Captured events latch into a status register. A single interrupt line goes high while any latched event is also enabled.

Every register takes up a 16-byte slot, and register `k` starts at byte address `k*0x10`. Within a slot, byte offset `0x0` writes the value directly. Offset `0x4` ORs in the bits written as one. Offset `0x8` clears the bits written as one. Offset `0xC` is reserved. Through these aliases, software can change single bits of any register in one bus write, without a read-modify-write. Status bits are acknowledged through the clear alias of the status slot. Reads return the register value at any offset of its slot.

Slot order by index: 0 output data, 1 input data (read-only), 2 output enable, 3 capture select, 4 interrupt enable, 5 mode (1 = level, 0 = edge), 6 polarity (1 = high/rising, 0 = low/falling), 7 status.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, all eight slots read as zero while the pins are low, `pin_out` and `pin_oe` are zero (every pin an input), and `irq_out` is low.
- R2: For the writable slots, a write at slot offset 0x0 loads the written value, at 0x4 sets the bits written as one, and at 0x8 clears the bits written as one. A write at 0x4 or 0x8 leaves all other bits unchanged, and a write at offset 0xC changes nothing.
- R3: `pin_out` always equals the output data slot (index 0) and `pin_oe` always equals the output enable slot (index 2).
- R4: The input data slot (index 1) returns `pin_in` through a two-flop synchroniser. A pin change set up before clock edge E0 is visible in a read after edge E1, and not after E0 alone. Writes to this slot at any offset are ignored.
- R5: In edge mode (mode bit 0), a selected pin sets its status bit on a rising edge when its polarity bit is 1 and on a falling edge when it is 0. The edge is taken from consecutive synchronised samples, so status is set at edge E2 for a pin change before E0. The opposite edge does nothing.
- R6: In level mode (mode bit 1), a selected pin sets its status bit on every cycle in which its synchronised level equals its polarity bit. A clear of that bit has no lasting effect until the pin is inactive.
- R7: A pin whose capture-select bit (slot 3) is 0 never sets its status bit, whatever its mode, polarity or activity.
- R8: `irq_out` is high exactly when at least one bit is set in both the status slot (index 7) and the interrupt enable slot (index 4).
- R9: When a pin event and a bus clear of the same status bit fall in the same cycle, the bit stays set.
- R10: The status slot accepts the direct write at 0x0 and the set alias at 0x4 like the other slots, and writing ones at its 0x8 alias acknowledges (clears) those bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus cycle select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | AW (8) | Byte address: slot index in bits [6:4], alias in bits [3:2] |
| bus_wdata | input | N (32) | Write data, one bit per pin |
| bus_rdata | output | N (32) | Read data of the addressed slot, combinational |
| pin_in | input | N (32) | Asynchronous pin levels |
| pin_out | output | N (32) | Output data levels |
| pin_oe | output | N (32) | Output enables, 1 = drive |
| irq_out | output | 1 | Combined port interrupt |

## Verification
The hardest case to reach is a status clear landing in exactly the cycle in which the pin still raises an event. A wrong priority shows for only one cycle before the level re-sets the bit. The stimulus holds a pin in its active level and issues the clear. It then samples `irq_out` in the clock period that directly follows the write edge, before any later cycle can hide the dropped bit. Sync latency is pinned the same way: a status or input read is taken one cycle early, and it must still show the old value.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   localparam int NUM_SLOTS = 8;
   localparam int SLOT_BITS = 4;
   localparam int IDX_W     = 3;

   typedef enum logic [IDX_W-1:0] {
      IDX_DOUT = 3'd0,
      IDX_DIN  = 3'd1,
      IDX_OE   = 3'd2,
      IDX_SEL  = 3'd3,
      IDX_EN   = 3'd4,
      IDX_LEV  = 3'd5,
      IDX_POL  = 3'd6,
      IDX_STAT = 3'd7
   } slot_idx_e;

   typedef enum logic [1:0] {
      OP_LOAD = 2'd0,
      OP_SET  = 2'd1,
      OP_CLR  = 2'd2,
      OP_RSVD = 2'd3
   } wr_op_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int N      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] async_i,
   output logic [N-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [N-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_pkg::*;
#(
   parameter int N  = 32,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_sel,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [N-1:0]  bus_wdata,
   input  logic [N-1:0]  din_i,
   input  logic [N-1:0]  stat_i,
   output logic [N-1:0]  dout_o,
   output logic [N-1:0]  oe_o,
   output logic [N-1:0]  sel_o,
   output logic [N-1:0]  en_o,
   output logic [N-1:0]  lev_o,
   output logic [N-1:0]  pol_o,
   output logic          stat_wr_o,
   output logic [N-1:0]  stat_wval_o,
   output logic [N-1:0]  rdata_o
);

   localparam int IDX_LSB = SLOT_BITS;
   localparam int IDX_MSB = SLOT_BITS + IDX_W - 1;

   function automatic logic [N-1:0] f_apply(wr_op_e op, logic [N-1:0] cur,
                                            logic [N-1:0] wd);
      case (op)
         OP_LOAD: f_apply = wd;
         OP_SET:  f_apply = cur | wd;
         OP_CLR:  f_apply = cur & ~wd;
         default: f_apply = cur;
      endcase
   endfunction

   logic                    in_range;
   logic [IDX_W-1:0]        idx;
   wr_op_e                  op;
   logic                    wr_ok;
   logic                    unused_lsb;
   logic [NUM_SLOTS-1:0][N-1:0] rd_vec;

   if (AW > IDX_MSB + 1) begin : g_upper
      assign in_range = (bus_addr[AW-1:IDX_MSB+1] == '0);
   end else begin : g_noupper
      assign in_range = 1'b1;
   end

   assign idx        = bus_addr[IDX_MSB:IDX_LSB];
   assign op         = wr_op_e'(bus_addr[IDX_LSB-1:IDX_LSB-2]);
   assign unused_lsb = ^bus_addr[IDX_LSB-3:0];
   assign wr_ok      = bus_sel && bus_wr && in_range && (op != OP_RSVD);

   for (genvar r = 0; r < NUM_SLOTS; r++) begin : g_slot
      if (r == int'(IDX_DIN)) begin : g_input
         assign rd_vec[r] = din_i;
      end else if (r == int'(IDX_STAT)) begin : g_status
         assign rd_vec[r] = stat_i;
      end else begin : g_rw
         logic         hit;
         logic [N-1:0] q;
         assign hit = wr_ok && (idx == IDX_W'(r));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= f_apply(op, q, bus_wdata);
         end
         assign rd_vec[r] = q;
      end
   end

   assign dout_o      = rd_vec[IDX_DOUT];
   assign oe_o        = rd_vec[IDX_OE];
   assign sel_o       = rd_vec[IDX_SEL];
   assign en_o        = rd_vec[IDX_EN];
   assign lev_o       = rd_vec[IDX_LEV];
   assign pol_o       = rd_vec[IDX_POL];

   assign stat_wr_o   = wr_ok && (idx == IDX_STAT);
   assign stat_wval_o = f_apply(op, stat_i, bus_wdata);

   assign rdata_o     = in_range ? rd_vec[idx] : '0;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sync_i,
   input  logic [N-1:0] sel_i,
   input  logic [N-1:0] en_i,
   input  logic [N-1:0] lev_i,
   input  logic [N-1:0] pol_i,
   input  logic         stat_wr_i,
   input  logic [N-1:0] stat_wval_i,
   output logic [N-1:0] stat_o,
   output logic         irq_o
);

   logic [N-1:0] prev_q;
   logic [N-1:0] stat_q;
   logic [N-1:0] hit;
   logic [N-1:0] stat_d;

   for (genvar i = 0; i < N; i++) begin : g_pin
      logic active_lvl;
      logic rise;
      logic fall;
      assign active_lvl = ~(sync_i[i] ^ pol_i[i]);
      assign rise       = sync_i[i] & ~prev_q[i];
      assign fall       = ~sync_i[i] & prev_q[i];
      assign hit[i]     = sel_i[i] &
                          (lev_i[i] ? active_lvl : (pol_i[i] ? rise : fall));
   end

   // A pin event is ORed in after the bus update, so it takes priority
   assign stat_d = (stat_wr_i ? stat_wval_i : stat_q) | hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         stat_q <= '0;
      end else begin
         prev_q <= sync_i;
         stat_q <= stat_d;
      end
   end

   assign stat_o = stat_q;
   assign irq_o  = |(stat_q & en_i);

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
   parameter int N           = 32,
   parameter int AW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_sel,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [N-1:0]  bus_wdata,
   output logic [N-1:0]  bus_rdata,
   input  logic [N-1:0]  pin_in,
   output logic [N-1:0]  pin_out,
   output logic [N-1:0]  pin_oe,
   output logic          irq_out
);

   localparam int MIN_AW = gpio_pkg::SLOT_BITS + gpio_pkg::IDX_W;

   if (N < 1 || N > 32) begin : g_bad_n
      $error("gpio_irq_port: N must lie in 1..32");
   end
   if (AW < MIN_AW) begin : g_bad_aw
      $error("gpio_irq_port: AW too small for eight 16-byte slots");
   end

   logic [N-1:0] sync_w;
   logic [N-1:0] dout_w;
   logic [N-1:0] oe_w;
   logic [N-1:0] sel_w;
   logic [N-1:0] en_w;
   logic [N-1:0] lev_w;
   logic [N-1:0] pol_w;
   logic [N-1:0] stat_w;
   logic         stat_wr_w;
   logic [N-1:0] stat_wval_w;

   gpio_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_in),
      .sync_o  (sync_w)
   );

   gpio_regfile #(.N(N), .AW(AW)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_sel     (bus_sel),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .din_i       (sync_w),
      .stat_i      (stat_w),
      .dout_o      (dout_w),
      .oe_o        (oe_w),
      .sel_o       (sel_w),
      .en_o        (en_w),
      .lev_o       (lev_w),
      .pol_o       (pol_w),
      .stat_wr_o   (stat_wr_w),
      .stat_wval_o (stat_wval_w),
      .rdata_o     (bus_rdata)
   );

   gpio_irq_detect #(.N(N)) u_detect (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_i      (sync_w),
      .sel_i       (sel_w),
      .en_i        (en_w),
      .lev_i       (lev_w),
      .pol_i       (pol_w),
      .stat_wr_i   (stat_wr_w),
      .stat_wval_i (stat_wval_w),
      .stat_o      (stat_w),
      .irq_o       (irq_out)
   );

   assign pin_out = dout_w;
   assign pin_oe  = oe_w;

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
   parameter int N      = 32,
   parameter int AW     = 8,
   parameter int STAGES = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_sel,
   input logic          bus_wr,
   input logic [AW-1:0] bus_addr,
   input logic [N-1:0]  pin_in,
   input logic [N-1:0]  pin_oe,
   input logic          irq_out,
   input logic [N-1:0]  sync,
   input logic [N-1:0]  stat,
   input logic [N-1:0]  sel,
   input logic [N-1:0]  en,
   input logic [N-1:0]  lev,
   input logic [N-1:0]  pol,
   input logic          stat_wr
);

   logic [1:0] cyc;
   logic       unused_chk;
   logic       oe_touch;

   assign unused_chk = ^bus_addr;
   assign oe_touch   = bus_sel && bus_wr && (bus_addr[6:4] == 3'd2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cyc <= 2'd0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   if (STAGES == 2) begin : g_sync2
      AST_DIN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
         (cyc >= 2'd2) |-> (sync == $past(pin_in, 2))); // R4
   end

   AST_NOSEL_NOCAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> ((stat & ~$past(stat) & ~$past(sel)) == '0)); // R7

   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel & lev & ~(sync ^ pol)) != '0) |=>
      ((stat & $past(sel & lev & ~(sync ^ pol))) == $past(sel & lev & ~(sync ^ pol)))); // R9

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat & en) == '0) |-> !irq_out); // R8

   AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_touch |=> $stable(pin_oe)); // R2

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N(N), .AW(AW), .STAGES(SYNC_STAGES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .pin_in   (pin_in),
   .pin_oe   (pin_oe),
   .irq_out  (irq_out),
   .sync     (sync_w),
   .stat     (stat_w),
   .sel      (sel_w),
   .en       (en_w),
   .lev      (lev_w),
   .pol      (pol_w),
   .stat_wr  (stat_wr_w)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/100ps
module sim_gpio_irq_port;

   localparam int K_REG = 0, K_IRQ = 1, K_OUT = 2, K_OE = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;
   logic        irq_out;

   int nchecks = 0;
   int nerrs   = 0;
   bit done    = 1'b0;

   int          q_kind [$];
   logic [7:0]  q_addr [$];
   logic [31:0] q_exp  [$];
   logic [31:0] q_mask [$];
   string       q_req  [$];

   always #4 clk = ~clk;

   gpio_irq_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
   );

   function automatic logic [7:0] slot(int idx, int op);
      return 8'(idx * 16 + op * 4);
   endfunction

   task automatic expect_it(int kind, logic [7:0] a, logic [31:0] e,
                            logic [31:0] m, string req);
      q_kind.push_back(kind);
      q_addr.push_back(a);
      q_exp.push_back(e);
      q_mask.push_back(m);
      q_req.push_back(req);
   endtask

   task automatic drain();
      while (q_kind.size() != 0) @(posedge clk);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   // write, with a check sampled in the period right after the write edge
   task automatic write_peek(logic [7:0] a, logic [31:0] d, int kind,
                             logic [31:0] e, string req);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      expect_it(kind, 8'h00, e, 32'hFFFF_FFFF, req);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      drain();
   endtask

   // monitor: pops expected items and compares them with the ports
   initial begin
      forever begin
         @(posedge clk);
         #3;
         while (q_kind.size() > 0) begin
            int          k;
            logic [7:0]  a;
            logic [31:0] e, m, act;
            string       rq;
            k = q_kind.pop_front(); a = q_addr.pop_front();
            e = q_exp.pop_front();  m = q_mask.pop_front();
            rq = q_req.pop_front();
            case (k)
               K_REG: begin bus_addr = a; #0.1; act = bus_rdata; end
               K_IRQ: act = {31'b0, irq_out};
               K_OUT: act = pin_out;
               default: act = pin_oe;
            endcase
            nchecks++;
            if ((act & m) != (e & m)) begin
               nerrs++;
               $display("FAIL %s: kind %0d addr %h actual %h expected %h (mask %h)",
                        rq, k, a, act & m, e & m, m);
            end
         end
      end
   end

   initial begin
      #(8 * 50000);
      if (!done) begin
         nerrs++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
         $finish;
      end
   end

   localparam logic [31:0] ALL = 32'hFFFF_FFFF;

   initial begin
      idle(3);
      rst_n = 1'b1;

      // R1: reset state
      for (int r = 0; r < 8; r++) expect_it(K_REG, slot(r, 0), 32'h0, ALL, "R1");
      expect_it(K_OUT, 8'h00, 32'h0, ALL, "R1");
      expect_it(K_OE,  8'h00, 32'h0, ALL, "R1");
      expect_it(K_IRQ, 8'h00, 32'h0, ALL, "R1");
      drain();

      // R2 / R3: aliases on output data and output enable
      bus_write(slot(0, 0), 32'hA5A5_0F0F);
      bus_write(slot(0, 1), 32'h0000_F000);
      bus_write(slot(0, 2), 32'hA500_0000);
      expect_it(K_REG, slot(0, 0), 32'h00A5_FF0F, ALL, "R2");
      expect_it(K_OUT, 8'h00, 32'h00A5_FF0F, ALL, "R3");
      drain();
      bus_write(slot(0, 3), ALL);
      expect_it(K_REG, slot(0, 0), 32'h00A5_FF0F, ALL, "R2");
      drain();
      bus_write(slot(2, 0), 32'h0000_FFFF);
      bus_write(slot(2, 1), 32'hFF00_0000);
      bus_write(slot(2, 2), 32'h0000_00F0);
      expect_it(K_REG, slot(2, 0), 32'hFF00_FF0F, ALL, "R2");
      expect_it(K_OE,  8'h00, 32'hFF00_FF0F, ALL, "R3");
      drain();

      // R4: input sync latency and read-only input slot
      @(negedge clk);
      pin_in = 32'h5A5A_0000;
      expect_it(K_REG, slot(1, 0), 32'h0, ALL, "R4");
      @(negedge clk);
      expect_it(K_REG, slot(1, 0), 32'h5A5A_0000, ALL, "R4");
      drain();
      bus_write(slot(1, 0), ALL);
      bus_write(slot(1, 2), 32'h5A5A_0000);
      expect_it(K_REG, slot(1, 0), 32'h5A5A_0000, ALL, "R4");
      drain();

      // interrupt configuration: mode, polarity, enable, then select
      bus_write(slot(5, 0), 32'h0000_000C);
      bus_write(slot(6, 0), 32'h0000_0035);
      bus_write(slot(4, 0), 32'h0000_001F);
      bus_write(slot(3, 0), 32'h0000_0027);
      expect_it(K_REG, slot(7, 0), 32'h0, ALL, "R7");
      expect_it(K_IRQ, 8'h00, 32'h0, ALL, "R8");
      drain();

      // R5: rising edge on pin 0 with exact latency
      @(negedge clk);
      pin_in[0] = 1'b1;
      expect_it(K_REG, slot(7, 0), 32'h0, 32'h1, "R5");
      @(negedge clk);
      expect_it(K_REG, slot(7, 0), 32'h0, 32'h1, "R5");
      @(negedge clk);
      expect_it(K_REG, slot(7, 0), 32'h1, 32'h1, "R5");
      expect_it(K_IRQ, 8'h00, 32'h1, ALL, "R8");
      drain();
      bus_write(slot(7, 2), 32'h1);
      expect_it(K_REG, slot(7, 0), 32'h0, 32'h1, "R10");
      expect_it(K_IRQ, 8'h00, 32'h0, ALL, "R10");
      drain();

      // R5: falling edge on pin 1, rising edge ignored
      @(negedge clk);
      pin_in[1] = 1'b1;
      idle(4);
      expect_it(K_REG, slot(7, 0), 32'h0, 32'h2, "R5");
      drain();
      @(negedge clk);
      pin_in[1] = 1'b0;
      idle(2);
      expect_it(K_REG, slot(7, 0), 32'h2, 32'h2, "R5");
      expect_it(K_IRQ, 8'h00, 32'h1, ALL, "R5");
      drain();
      bus_write(slot(7, 2), 32'h2);
      expect_it(K_REG, slot(7, 0), 32'h0, 32'h2, "R10");
      drain();

      // R6 / R9: level high on pin 2, clear while active
      @(negedge clk);
      pin_in[2] = 1'b1;
      idle(2);
      expect_it(K_REG, slot(7, 0), 32'h4, 32'h4, "R6");
      drain();
      write_peek(slot(7, 2), 32'h4, K_IRQ, 32'h1, "R9");
      expect_it(K_REG, slot(7, 0), 32'h4, 32'h4, "R6");
      drain();
      @(negedge clk);
      pin_in[2] = 1'b0;
      idle(3);
      bus_write(slot(7, 2), 32'h4);
      expect_it(K_REG, slot(7, 0), 32'h0, 32'h4, "R6");
      expect_it(K_IRQ, 8'h00, 32'h0, ALL, "R6");
      drain();

      // R6: level low on pin 3, selected while already low
      bus_write(slot(3, 1), 32'h8);
      expect_it(K_REG, slot(7, 0), 32'h8, 32'h8, "R6");
      expect_it(K_IRQ, 8'h00, 32'h1, ALL, "R6");
      expect_it(K_REG, slot(3, 0), 32'h2F, ALL, "R2");
      drain();
      @(negedge clk);
      pin_in[3] = 1'b1;
      idle(3);
      bus_write(slot(7, 2), 32'h8);
      expect_it(K_REG, slot(7, 0), 32'h0, 32'h8, "R6");
      drain();

      // R7: unselected pin 4 rises, no capture
      @(negedge clk);
      pin_in[4] = 1'b1;
      idle(4);
      expect_it(K_REG, slot(7, 0), 32'h0, 32'h10, "R7");
      expect_it(K_IRQ, 8'h00, 32'h0, ALL, "R7");
      drain();

      // R8: pin 5 captured while disabled, then enabled
      @(negedge clk);
      pin_in[5] = 1'b1;
      idle(3);
      expect_it(K_REG, slot(7, 0), 32'h20, 32'h20, "R8");
      expect_it(K_IRQ, 8'h00, 32'h0, ALL, "R8");
      drain();
      bus_write(slot(4, 1), 32'h20);
      expect_it(K_IRQ, 8'h00, 32'h1, ALL, "R8");
      expect_it(K_REG, slot(4, 0), 32'h3F, ALL, "R2");
      drain();
      bus_write(slot(7, 2), 32'h20);
      expect_it(K_IRQ, 8'h00, 32'h0, ALL, "R10");
      drain();

      // R10: direct and set writes to status
      bus_write(slot(7, 1), 32'h0010_0000);
      expect_it(K_REG, slot(7, 0), 32'h0010_0000, ALL, "R10");
      expect_it(K_IRQ, 8'h00, 32'h0, ALL, "R8");
      drain();
      bus_write(slot(7, 0), 32'h0000_0001);
      expect_it(K_REG, slot(7, 0), 32'h0000_0001, ALL, "R10");
      expect_it(K_IRQ, 8'h00, 32'h1, ALL, "R8");
      drain();
      bus_write(slot(7, 0), 32'h0);
      expect_it(K_REG, slot(7, 0), 32'h0, ALL, "R10");
      expect_it(K_IRQ, 8'h00, 32'h0, ALL, "R10");
      drain();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
   end

endmodule